// File: doc/BRIEF.md
# Start-Gated Pulse Decimation Counter

This block watches a short pulse that arrives from outside the clock domain and reports after a programmed number of those pulses. It begins each run only when a start command arrives. The pulse is sampled by two flip-flops on the system clock. It then passes through a rising-edge detector, so each pulse counts once however many clocks it lasts. At the end of a run the block raises a one-cycle completion flag and returns to idle. It then waits for the next start.

A typical use is decimation of a 100 kHz strobe that is 50 to 100 ns wide, on a 40 MHz clock. Such a strobe is about 2 to 4 clocks high. The completion flag triggers a downstream sequencer. The pulse line is only ever sampled as data and never drives a clock.

Top module: `pulse_decimator`

## Requirements
- R1: The raw pulse passes through a two-flop synchronizer and a rising-edge detector. Each pulse advances the count exactly once, whether it stays high for 2, 3 or 4 clocks.
- R2: While idle, pulses have no effect. A start that is high at a rising clock edge while idle begins a new run with the count at zero.
- R3: When the number of pulses counted in a run equals the programmed value, done goes high and the block returns to idle. Latency: if pulse_in is first seen high at rising edge k, done is high in the cycle after edge k+2.
- R4: done is high for exactly one clock cycle per completed run.
- R5: count_target is 16 bits wide, as an unsigned integer. It is captured when start is accepted, and later changes to it do not affect the run in progress.
- R6: A count_target of 0 acts as 1, so done follows the first pulse after start.
- R7: start asserted during a run is ignored. The run keeps its progress and completes after the remaining pulses.
- R8: rst_n is asynchronous and active low. While it is low, done is 0. After it is released, the block is idle with no run in progress.
- R9: A pulse whose synchronized rising edge arrives in the same cycle that start is accepted is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arms a run when the block is idle |
| pulse_in | input | 1 | Raw pulse, asynchronous to clk |
| count_target | input | 16 | Number of pulses per run, 0 treated as 1 |
| done | output | 1 | One-cycle flag at the end of a run |

## Verification
Start acceptance and the arrival of a synchronized edge can fall in the same clock cycle. To provoke this, the bench raises pulse_in and then asserts start two falling edges later, so both events reach the state logic on one rising edge. The bench passes the check if that pulse brings no done under a target of 1 and the following pulse does. If the RTL counted the pulse in that cycle, or dropped the start, the result would differ.

// File: rtl/pulse_decimator.sv
module pulse_decimator #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         pulse_in,
  input  logic [W-1:0] count_target,
  output logic         done
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [2:0]   sh;
  logic         busy;
  logic [W-1:0] tgt;
  logic [W-1:0] cnt;

  wire          hit    = sh[1] & ~sh[2];
  wire [W-1:0]  cnt_nx = cnt + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      busy <= 1'b0;
      tgt  <= ONE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      sh   <= {sh[1:0], pulse_in};
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          tgt  <= (count_target == '0) ? ONE : count_target;
        end
      end else if (hit) begin
        if (cnt_nx == tgt) begin
          done <= 1'b1;
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_decimator_chk.sv
module pulse_decimator_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         busy,
  input logic [W-1:0] cnt,
  input logic [W-1:0] tgt
);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r5_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(tgt)));

  a_r6_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tgt != '0));

  a_r3_count_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < tgt));

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !done);
endmodule

bind pulse_decimator pulse_decimator_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .busy(busy), .cnt(cnt), .tgt(tgt)
);

// File: tb/tb_pulse_decimator.sv
module tb_pulse_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pulse_in = 1'b0;
  logic [15:0] count_target = '0;
  logic        done;

  int checks = 0;
  int errors = 0;
  int ndone  = 0;
  int base;

  always #5 clk = ~clk;

  pulse_decimator dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse_in(pulse_in),
    .count_target(count_target), .done(done)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n && done) ndone++;
  end

  function automatic int pulses_needed(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int width, input int gap);
    pulse_in = 1'b1;
    repeat (width) @(negedge clk);
    pulse_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rsend();
    send($urandom_range(2, 4), $urandom_range(3, 7));
  endtask

  task automatic do_start(input int t);
    count_target = 16'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int t, input string req);
    int n;
    n = pulses_needed(t);
    do_start(t);
    base = ndone;
    for (int i = 0; i < n - 1; i++) rsend();
    check(req, ndone - base, 0);
    rsend();
    check(req, ndone - base, 1);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R8 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    base = ndone;
    repeat (3) send(3, 4);
    check("R2 idle ignores pulses", ndone - base, 0);

    do_start(1);
    pulse_in = 1'b1;
    @(negedge clk); check("R3 latency e+1", int'(done), 0);
    @(negedge clk); check("R3 latency e+2", int'(done), 0);
    @(negedge clk); check("R3 latency e+3", int'(done), 1);
    pulse_in = 1'b0;
    @(negedge clk); check("R4 one cycle", int'(done), 0);
    repeat (4) @(negedge clk);

    do_start(0);
    base = ndone;
    send(3, 5);
    check("R6 zero acts as one", ndone - base, 1);

    do_start(4);
    base = ndone;
    send(2, 4); send(4, 4); send(3, 4);
    check("R1 widths 2..4", ndone - base, 0);
    send(2, 5);
    check("R1 widths 2..4", ndone - base, 1);

    do_start(3);
    base = ndone;
    send(3, 4);
    count_target = 16'd1;
    send(3, 4);
    check("R5 target captured", ndone - base, 0);
    send(3, 5);
    check("R5 target captured", ndone - base, 1);

    do_start(3);
    base = ndone;
    send(3, 4);
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    send(3, 4);
    check("R7 start ignored mid-run", ndone - base, 0);
    send(3, 5);
    check("R7 start ignored mid-run", ndone - base, 1);

    count_target = 16'd1;
    base = ndone;
    pulse_in = 1'b1;
    @(negedge clk); @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; pulse_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 edge at start not counted", ndone - base, 0);
    send(3, 5);
    check("R9 next pulse counted", ndone - base, 1);

    do_start(2);
    base = ndone;
    send(3, 2);
    rst_n = 1'b0;
    @(negedge clk); check("R8 async reset done low", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (3) send(3, 4);
    check("R8 idle after reset", ndone - base, 0);

    run(1000, "R5 wide target");

    for (int k = 0; k < 20; k++) run($urandom_range(0, 12), "R3 random run");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule